// File: doc/BRIEF.md
# Sampling Converter Serial Acquisition Master

This block is the host end of a serial link to a 12-bit successive-approximation converter whose output word is 14 bits long. From the system clock it produces the active-low select line and a serial clock that idles high, collects the converter's serial output, and hands each result to the host logic as a signed 12-bit value with a one-cycle strobe. Every interval the converter needs is set in system-clock cycles through a parameter: the select-to-clock setup, the half period of the serial clock, the hold from the last clock to the select rising, and the quiet time between frames, which is the longer of the minimum select-high time and the acquisition time.

After reset the block first waits one full quiet time and then, without any request, runs a 16-clock calibration frame whose data it drops. After that it reports `ready`. A read request starts a 14-clock frame. A calibration request starts a 32-clock frame, which also delivers the sample taken at its start. The block drops the two leading bits of each word and raises an error flag when either of them is not zero.

Top module: `sar_acq_ctrl`

## Requirements
- R1: While reset is held and in the cycle it is released, `cs_n` and `sclk` are 1, and `ready` and `sample_valid` are 0.
- R2: `sclk` is 1 whenever `cs_n` is 1. Within a frame, every low phase of `sclk` and every high phase between two falling edges lasts exactly SCLK_HALF cycles.
- R3: The first falling edge of `sclk` in a frame comes at least SETUP_CNT cycles after `cs_n` falls.
- R4: `cs_n` rises at least HOLD_CNT cycles after the last falling edge of `sclk` in the frame, and `sclk` is 1 when it rises.
- R5: `cs_n` stays high for at least max(CSHIGH_CNT, ACQ_CNT) cycles between frames, and also from the release of reset to the first frame.
- R6: After reset, a frame of 16 `sclk` falling edges starts with no request. It gives no `sample_valid`, and `ready` stays 0 until it has ended.
- R7: When `read_req` is 1 in a cycle where `ready` is 1 and `cal_req` is 0, the block runs a frame of 14 `sclk` falling edges and pulses `sample_valid` once. The first word bit is taken from `sdo` at the end of the setup interval, and bits 2 to 14 are taken on rising edges 1 to 13. Word bits 3 to 14 are `sample` in two's complement, MSB first.
- R8: When `cal_req` is 1 in a cycle where `ready` is 1, the block runs a frame of 32 `sclk` falling edges and delivers its sample in the same way as R7. Values on `sdo` after the 14th word bit have no effect on `sample`.
- R9: When `cal_req` and `read_req` are both 1 in a ready cycle, the 32-clock frame is chosen.
- R10: `proto_err` is 1 together with `sample_valid` exactly when word bit 1 or word bit 2 is 1. The 12-bit `sample` is delivered either way.
- R11: Requests are only taken in a cycle where `ready` is 1, and `ready` is 1 only while `cs_n` and `sclk` are 1. A request pulse during a frame starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_req | input | 1 | Request a 14-clock read frame; taken while ready |
| cal_req | input | 1 | Request a 32-clock read-plus-calibration frame; taken while ready |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low frame select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| ready | output | 1 | Idle and able to take a request |
| sample_valid | output | 1 | One-cycle strobe: `sample` holds a new result |
| sample | output | DATA_W | Signed conversion result |
| proto_err | output | 1 | A leading word bit was nonzero; valid with the strobe |

## Verification
On every cycle the assertions check these rules: the serial clock rests high outside frames, the select line rises only while the clock is high, and the quiet time between frames is never shorter than the configured minimum. They also check that each frame has 14, 16 or 32 falling edges, that the strobe and error flag appear only inside a frame, and that `ready` is shown only while the link is idle. Only the directed scenarios, run against a bit-accurate converter model, can show the rest. These are the decoded sample values for positive, negative and extreme codes, the dropped power-up frame, the tail bits that have no effect, the priority of calibration over read, the error flag, and the setup, half-period and hold lengths measured in cycles.

// File: rtl/sac_pkg.sv
`timescale 1ns/1ps
package sac_pkg;
   typedef enum logic [2:0] {
      ST_GAP, ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD
   } sac_state_e;

   typedef enum logic [1:0] {
      FR_PWRCAL, FR_READ, FR_RDCAL
   } sac_frame_e;

   localparam int unsigned SAC_LEAD_BITS  = 2;
   localparam int unsigned SAC_CLK_PWRCAL = 16;
   localparam int unsigned SAC_CLK_READ   = 14;
   localparam int unsigned SAC_CLK_RDCAL  = 32;

   function automatic int unsigned sac_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sac_interval.sv
`timescale 1ns/1ps
// Down-counting interval timer: after load with N-1 the done flag rises N cycles later.
module sac_interval #(
   parameter int unsigned TW      = 5,
   parameter int unsigned RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= TW'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sac_capture.sv
`timescale 1ns/1ps
// Serial word capture with optional input synchronizer stages.
module sac_capture #(
   parameter int unsigned WORD_W      = 14,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              sdo,
   output logic [WORD_W-1:0] word,
   output logic              done_pulse
);
   localparam int unsigned CW = $clog2(WORD_W + 1);

   logic          sdo_s;
   logic [CW-1:0] cnt_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sdo_s = sdo;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[0] <= 1'b0;
            else        pipe_q[0] <= sdo;
         end
         for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[i] <= 1'b0;
               else        pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign sdo_s = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         word       <= '0;
         done_pulse <= 1'b0;
      end else if (clr) begin
         cnt_q      <= '0;
         word       <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (shift && (cnt_q < CW'(WORD_W))) begin
            word       <= {word[WORD_W-2:0], sdo_s};
            cnt_q      <= cnt_q + 1'b1;
            done_pulse <= (cnt_q == CW'(WORD_W - 1));
         end
      end
   end
endmodule

// File: rtl/sar_acq_ctrl.sv
`timescale 1ns/1ps
module sar_acq_ctrl
   import sac_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SCLK_HALF   = 4,
   parameter int unsigned SETUP_CNT   = 2,
   parameter int unsigned HOLD_CNT    = 1,
   parameter int unsigned CSHIGH_CNT  = 6,
   parameter int unsigned ACQ_CNT     = 20,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              read_req,
   input  logic              cal_req,
   input  logic              sdo,
   output logic              cs_n,
   output logic              sclk,
   output logic              ready,
   output logic              sample_valid,
   output logic [DATA_W-1:0] sample,
   output logic              proto_err
);
   localparam int unsigned WORD_W  = DATA_W + SAC_LEAD_BITS;
   localparam int unsigned GAP_CNT = sac_max(CSHIGH_CNT, ACQ_CNT);
   localparam int unsigned MAX_CNT = sac_max(sac_max(SCLK_HALF, SETUP_CNT),
                                             sac_max(HOLD_CNT, GAP_CNT));
   localparam int unsigned TW      = $clog2(MAX_CNT + 1);
   localparam int unsigned EW      = $clog2(SAC_CLK_RDCAL + 1);

   generate
      if (SCLK_HALF < 1 || SETUP_CNT < 1 || HOLD_CNT < 1 ||
          CSHIGH_CNT < 1 || ACQ_CNT < 1) begin : g_bad_interval
         $error("sar_acq_ctrl: every interval count must be at least 1");
      end
      if (SYNC_STAGES >= SCLK_HALF) begin : g_bad_sync
         $error("sar_acq_ctrl: SYNC_STAGES must be below SCLK_HALF");
      end
      if (DATA_W < 1 || WORD_W > SAC_CLK_READ) begin : g_bad_width
         $error("sar_acq_ctrl: word does not fit a read frame");
      end
   endgenerate

   sac_state_e    st_q, st_d;
   sac_frame_e    kind_q, kind_d;
   logic          pwr_pend_q, pwr_pend_d;
   logic [EW-1:0] ecnt_q;
   logic          ecnt_inc, frame_start;
   logic          tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;
   logic          cap_shift, cap_done;
   logic [WORD_W-1:0] word;
   logic          cs_n_q, sclk_q;

   function automatic logic [EW-1:0] clocks_of(input sac_frame_e k);
      case (k)
         FR_PWRCAL: return EW'(SAC_CLK_PWRCAL);
         FR_RDCAL:  return EW'(SAC_CLK_RDCAL);
         default:   return EW'(SAC_CLK_READ);
      endcase
   endfunction

   sac_interval #(.TW(TW), .RST_VAL(GAP_CNT - 1)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sac_capture #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) cap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (frame_start),
      .shift      (cap_shift),
      .sdo        (sdo),
      .word       (word),
      .done_pulse (cap_done)
   );

   always_comb begin
      st_d        = st_q;
      kind_d      = kind_q;
      pwr_pend_d  = pwr_pend_q;
      tmr_load    = 1'b0;
      tmr_val     = '0;
      frame_start = 1'b0;
      cap_shift   = 1'b0;
      ecnt_inc    = 1'b0;
      case (st_q)
         ST_GAP: if (tmr_done) begin
            if (pwr_pend_q) begin
               st_d        = ST_SETUP;
               kind_d      = FR_PWRCAL;
               pwr_pend_d  = 1'b0;
               frame_start = 1'b1;
               tmr_load    = 1'b1;
               tmr_val     = TW'(SETUP_CNT - 1);
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_IDLE: if (cal_req || read_req) begin
            st_d        = ST_SETUP;
            kind_d      = cal_req ? FR_RDCAL : FR_READ;
            frame_start = 1'b1;
            tmr_load    = 1'b1;
            tmr_val     = TW'(SETUP_CNT - 1);
         end
         ST_SETUP: if (tmr_done) begin
            st_d      = ST_LOW;
            cap_shift = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = TW'(SCLK_HALF - 1);
         end
         ST_LOW: if (tmr_done) begin
            st_d      = ST_HIGH;
            cap_shift = 1'b1;
            ecnt_inc  = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = TW'(SCLK_HALF - 1);
         end
         ST_HIGH: if (tmr_done) begin
            tmr_load = 1'b1;
            if (ecnt_q == clocks_of(kind_q)) begin
               st_d    = ST_HOLD;
               tmr_val = TW'(HOLD_CNT - 1);
            end else begin
               st_d    = ST_LOW;
               tmr_val = TW'(SCLK_HALF - 1);
            end
         end
         ST_HOLD: if (tmr_done) begin
            st_d     = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = TW'(GAP_CNT - 1);
         end
         default: st_d = ST_GAP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_GAP;
         kind_q     <= FR_PWRCAL;
         pwr_pend_q <= 1'b1;
         ecnt_q     <= '0;
         cs_n_q     <= 1'b1;
         sclk_q     <= 1'b1;
      end else begin
         st_q       <= st_d;
         kind_q     <= kind_d;
         pwr_pend_q <= pwr_pend_d;
         if (frame_start)   ecnt_q <= '0;
         else if (ecnt_inc) ecnt_q <= ecnt_q + 1'b1;
         cs_n_q <= (st_d == ST_GAP) || (st_d == ST_IDLE);
         sclk_q <= (st_d != ST_LOW);
      end
   end

   assign cs_n         = cs_n_q;
   assign sclk         = sclk_q;
   assign ready        = (st_q == ST_IDLE);
   assign sample_valid = cap_done && (kind_q != FR_PWRCAL);
   assign sample       = word[DATA_W-1:0];
   assign proto_err    = sample_valid && (|word[WORD_W-1:DATA_W]);
endmodule

// File: rtl/sar_acq_ctrl_chk.sv
`timescale 1ns/1ps
module sar_acq_ctrl_chk #(
   parameter int unsigned CSHIGH_CNT = 6,
   parameter int unsigned ACQ_CNT    = 20
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic ready,
   input logic sample_valid,
   input logic proto_err
);
   localparam int unsigned GAP_CNT = (CSHIGH_CNT > ACQ_CNT) ? CSHIGH_CNT : ACQ_CNT;
   localparam int unsigned HW      = $clog2(GAP_CNT + 2);

   logic [HW-1:0] hi_cnt;
   logic [5:0]    fall_cnt;
   logic          sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         fall_cnt <= '0;
         sclk_d   <= 1'b1;
      end else begin
         sclk_d <= sclk;
         if (!cs_n)                      hi_cnt <= '0;
         else if (hi_cnt < HW'(GAP_CNT)) hi_cnt <= hi_cnt + 1'b1;
         if (cs_n)                 fall_cnt <= '0;
         else if (sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
      end
   end

   assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   assert_cs_rise_sclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (sclk && $past(sclk)));

   assert_cs_high_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CNT)));

   // Frame lengths of R6, R7 and R8.
   assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (fall_cnt == 6'd14 || fall_cnt == 6'd16 || fall_cnt == 6'd32));

   assert_valid_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> !cs_n);

   assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> sample_valid);

   assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cs_n && sclk));
endmodule

bind sar_acq_ctrl sar_acq_ctrl_chk #(.CSHIGH_CNT(CSHIGH_CNT), .ACQ_CNT(ACQ_CNT)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .sclk         (sclk),
   .ready        (ready),
   .sample_valid (sample_valid),
   .proto_err    (proto_err)
);

// File: tb/sar_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_acq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF  = 4;
   localparam int SETUP = 2;
   localparam int HOLD  = 1;
   localparam int GAP   = 20;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic read_req = 1'b0;
   logic cal_req = 1'b0;
   logic sdo = 1'b0;
   logic cs_n, sclk, ready, sample_valid, proto_err;
   logic [11:0] sample;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_acq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .read_req(read_req), .cal_req(cal_req), .sdo(sdo),
      .cs_n(cs_n), .sclk(sclk), .ready(ready), .sample_valid(sample_valid),
      .sample(sample), .proto_err(proto_err)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Converter model: word bit 1 on select fall, next bits on clock falls.
   logic [1:0]  s_lead = 2'b11;
   logic [11:0] s_data = 12'hFFF;
   logic        s_tail = 1'b1;
   int          s_idx  = 0;

   function automatic logic bitv(input int i);
      if (i < 2)       return s_lead[1-i];
      else if (i < 14) return s_data[13-i];
      else             return s_tail;
   endfunction

   always @(negedge cs_n) begin
      s_idx = 0;
      #3 sdo = bitv(0);
   end
   always @(negedge sclk) if (!cs_n) begin
      s_idx++;
      #3 sdo = bitv(s_idx);
   end

   // Link monitor, sampled on the falling clock edge.
   int run = 0, since_fall = 0, falls = 0, frames = 0, last_falls = 0, valid_cnt = 0;
   int viol_half = 0, viol_setup = 0, viol_hold = 0, viol_gap = 0, viol_idle = 0;
   int ready_early = 0;
   logic [11:0] last_sample = '0;
   logic last_err = 1'b0;
   logic p_cs = 1'b1, p_sclk = 1'b1;

   always @(negedge clk) begin
      if (!rst_n) begin
         run = 0; p_cs = 1'b1; p_sclk = 1'b1;
      end else begin
         if (cs_n && !sclk) viol_idle++;
         if (ready && frames == 0) ready_early++;
         if (cs_n != p_cs || sclk != p_sclk) begin
            if (!cs_n && p_cs) begin
               if (run < GAP) viol_gap++;
               falls = 0;
            end else if (cs_n && !p_cs) begin
               if (since_fall < HOLD) viol_hold++;
               last_falls = falls;
               frames++;
            end else if (!sclk && p_sclk) begin
               if (falls == 0) begin
                  if (run < SETUP) viol_setup++;
               end else if (run != HALF) viol_half++;
               falls++;
            end else if (sclk && !p_sclk) begin
               if (run != HALF) viol_half++;
            end
            run = 1;
         end else run++;
         if (!cs_n && !sclk && p_sclk) since_fall = 1; else since_fall++;
         if (sample_valid) begin
            valid_cnt++;
            last_sample = sample;
            last_err = proto_err;
         end
         p_cs = cs_n;
         p_sclk = sclk;
      end
   end

   task automatic wait_ready();
      while (!ready) @(negedge clk);
   endtask

   task automatic wait_frames(input int target);
      while (frames < target) @(negedge clk);
   endtask

   task automatic issue(input bit rd, input bit cl);
      read_req = rd;
      cal_req  = cl;
      @(negedge clk);
      read_req = 1'b0;
      cal_req  = 1'b0;
   endtask

   task automatic frame_check(input bit rd, input bit cl, input logic [1:0] lead,
                              input logic [11:0] data, input logic tail,
                              input int exp_falls, input string req);
      int f0, v0;
      wait_ready();
      s_lead = lead; s_data = data; s_tail = tail;
      f0 = frames; v0 = valid_cnt;
      issue(rd, cl);
      wait_frames(f0 + 1);
      chk(last_falls == exp_falls, {req, " clock count"}, last_falls, exp_falls);
      chk(valid_cnt - v0 == 1, {req, " valid pulses"}, valid_cnt - v0, 1);
      chk(last_sample == data, {req, " sample"}, int'(last_sample), int'(data));
      chk(last_err == (lead != 2'b00), "R10 error flag", int'(last_err), int'(lead != 2'b00));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
      chk(sclk == 1'b1, "R1 sclk in reset", int'(sclk), 1);
      chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
      chk(sample_valid == 1'b0, "R1 valid in reset", int'(sample_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_powerup();
      wait_frames(1);
      chk(last_falls == 16, "R6 power-up clock count", last_falls, 16);
      chk(valid_cnt == 0, "R6 power-up data dropped", valid_cnt, 0);
      chk(ready_early == 0, "R6 ready held low", ready_early, 0);
   endtask

   task automatic t_reads();
      frame_check(1'b1, 1'b0, 2'b00, 12'h5A3, 1'b0, 14, "R7 positive read");
      frame_check(1'b1, 1'b0, 2'b00, 12'h800, 1'b0, 14, "R7 most negative read");
      frame_check(1'b1, 1'b0, 2'b00, 12'h7FF, 1'b0, 14, "R7 most positive read");
   endtask

   task automatic t_cal();
      frame_check(1'b0, 1'b1, 2'b00, 12'h123, 1'b1, 32, "R8 calibration frame");
   endtask

   task automatic t_priority();
      frame_check(1'b1, 1'b1, 2'b00, 12'hC3C, 1'b1, 32, "R9 both requests");
   endtask

   task automatic t_err();
      frame_check(1'b1, 1'b0, 2'b01, 12'h0F0, 1'b0, 14, "R10 second bit set");
      frame_check(1'b1, 1'b0, 2'b10, 12'hABC, 1'b0, 14, "R10 first bit set");
   endtask

   task automatic t_ignore();
      int f0;
      wait_ready();
      s_lead = 2'b00; s_data = 12'h321; s_tail = 1'b0;
      f0 = frames;
      issue(1'b1, 1'b0);
      while (cs_n) @(negedge clk);
      repeat (10) @(negedge clk);
      issue(1'b1, 1'b0);
      wait_frames(f0 + 1);
      repeat (GAP + 30) @(negedge clk);
      chk(frames == f0 + 1, "R11 busy request dropped", frames, f0 + 1);
      chk(ready == 1'b1, "R11 ready after frame", int'(ready), 1);
      chk(last_sample == 12'h321, "R11 sample of taken frame", int'(last_sample), 'h321);
   endtask

   task automatic t_timing();
      chk(viol_idle == 0, "R2 sclk idle high", viol_idle, 0);
      chk(viol_half == 0, "R2 half period", viol_half, 0);
      chk(viol_setup == 0, "R3 setup interval", viol_setup, 0);
      chk(viol_hold == 0, "R4 hold interval", viol_hold, 0);
      chk(viol_gap == 0, "R5 quiet time", viol_gap, 0);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_powerup();
      t_reads();
      t_cal();
      t_priority();
      t_err();
      t_ignore();
      t_timing();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule